// File: doc/BRIEF.md
# Program Memory Bank Translator

This block maps the upper part of a CPU address space, from 0x6000 to 0xFFFF, onto a larger physical memory. It does this in 8 KB pages. For every CPU address it gives three results: a physical page-and-offset address, a flag that picks work RAM or ROM, and a flag that permits a write to the battery-backed RAM. A register write port loads the configuration. That configuration is a 2-bit banking mode, five 8-bit bank registers and two write-protect registers.

The four banking modes split the 32 KB region from 0x8000 into windows of different sizes. A 32 KB window takes its bank number with the low two bits cleared, and a 16 KB window takes it with bit 0 cleared. The CPU address fills in those cleared bits. The result is combinational in the CPU address and in the register contents. A register write takes effect on the clock edge that captures it.

Top module: `prg_bank_xlate`

## Requirements
- R1: Register writes are captured on the rising clock edge while `reg_we` is high. The decode uses the full 8-bit offset: 0x00 mode (low 2 bits kept), 0x02 protect key A (low 2 bits kept), 0x03 protect key B (low 2 bits kept), and 0x13 to 0x17 for the five bank registers B0 to B4. A write to any other offset changes nothing.
- R2: Addresses 0x6000 to 0x7FFF always select RAM, with bank number B0[2:0]. Bit 7 of B0 has no effect.
- R3: In mode 0, all of 0x8000 to 0xFFFF is one ROM window. Its bank number is {B4[6:2], cpu_addr[14:13]}.
- R4: In mode 1, 0x8000 to 0xBFFF uses B2 and 0xC000 to 0xFFFF uses B4. Each forms its bank number from the register with bit 0 replaced by cpu_addr[13].
- R5: In mode 2, 0x8000 to 0xBFFF uses B2 with bit 0 replaced by cpu_addr[13]. 0xC000 to 0xDFFF uses B3 and 0xE000 to 0xFFFF uses B4, both unmasked.
- R6: In mode 3, the 8 KB windows at 0x8000, 0xA000, 0xC000 and 0xE000 use B1, B2, B3 and B4 in that order.
- R7: For B1 to B3, bit 7 low selects RAM with bank bits [2:0], and bit 7 high selects ROM with bank bits [6:0]. B4 always selects ROM with bits [6:0], whatever its bit 7 holds.
- R8: `ram_wr_ok` is high only when RAM is selected, key A[1:0] equals 2 and key B[1:0] equals 1.
- R9: After reset the mode is 3, B4 holds 0xFF, and all other registers hold 0.
- R10: `phys_addr` is {bank[6:0], cpu_addr[12:0]}, with a RAM bank zero-extended to 7 bits. For addresses below 0x6000, `phys_addr` is 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset within the page |
| reg_wdata | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address to translate |
| phys_addr | output | 20 | Physical page and offset |
| sel_ram | output | 1 | High: work RAM, low: ROM |
| ram_wr_ok | output | 1 | Write permitted to the selected RAM |

## Verification
Some properties are checked on every cycle, whatever the configuration:
- the RAM window at 0x6000 always selects RAM;
- the top window never selects RAM;
- mode 0 never selects RAM;
- the page offset always passes through unchanged;
- unmapped addresses give zeros;
- a write permit never appears without RAM;
- the mode holds when it is not written.

Only the bench's scenarios can show the exact bank numbers for each mode and window, and which bits are masked. They also show the write key's exact values, that writes to unused offsets are ignored, and the reset contents. The bench covers these with random register traffic and addresses, plus directed corner cases.

// File: rtl/prg_xlate_pkg.sv
package prg_xlate_pkg;

   // Register offsets inside the register page (decoded by neighbours, kept fixed)
   localparam logic [7:0] OFF_MODE   = 8'h00;
   localparam logic [7:0] OFF_KEY_A  = 8'h02;
   localparam logic [7:0] OFF_KEY_B  = 8'h03;
   localparam logic [7:0] OFF_BANK0  = 8'h13;

   localparam int NUM_BANK = 5;

   // Write key values (low 2 bits of each protect register)
   localparam logic [1:0] KEY_A_VAL = 2'd2;
   localparam logic [1:0] KEY_B_VAL = 2'd1;

   typedef enum logic [1:0] {
      MODE_32K = 2'd0,
      MODE_16K = 2'd1,
      MODE_MIX = 2'd2,
      MODE_8K  = 2'd3
   } bank_mode_e;

endpackage

// File: rtl/prg_xlate_regs.sv
module prg_xlate_regs
   import prg_xlate_pkg::*;
#(
   parameter int DW   = 8,
   parameter int RA_W = 8,
   parameter int NB   = NUM_BANK
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [RA_W-1:0]        addr,
   input  logic [DW-1:0]          wdata,
   output bank_mode_e             mode_q,
   output logic [1:0]             key_a_q,
   output logic [1:0]             key_b_q,
   output logic [NB-1:0][DW-1:0]  bank_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_8K;
         key_a_q <= '0;
         key_b_q <= '0;
      end else if (we) begin
         if (addr == RA_W'(OFF_MODE))  mode_q  <= bank_mode_e'(wdata[1:0]);
         if (addr == RA_W'(OFF_KEY_A)) key_a_q <= wdata[1:0];
         if (addr == RA_W'(OFF_KEY_B)) key_b_q <= wdata[1:0];
      end
   end

   // One register per bank; the last one resets to all ones so the
   // top ROM page is mapped out of reset.
   for (genvar i = 0; i < NB; i++) begin : g_bank
      localparam logic [DW-1:0] RST_VAL = (i == NB-1) ? {DW{1'b1}} : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[i] <= RST_VAL;
         else if (we && addr == RA_W'(OFF_BANK0) + RA_W'(i))
            bank_q[i] <= wdata;
      end
   end

endmodule

// File: rtl/prg_xlate_sel.sv
module prg_xlate_sel
   import prg_xlate_pkg::*;
#(
   parameter int NB    = NUM_BANK,
   parameter int IDX_W = $clog2(NB)
) (
   input  logic [2:0]       win,      // cpu_addr[15:13]
   input  bank_mode_e       mode,
   output logic             in_map,
   output logic [IDX_W-1:0] idx,
   output logic [1:0]       low_cnt   // number of bank bits taken from the address
);

   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NB-1);

   always_comb begin
      in_map  = 1'b1;
      idx     = '0;
      low_cnt = 2'd0;
      if (win < 3'd3) begin
         in_map = 1'b0;
      end else if (win == 3'd3) begin
         idx = '0;
      end else begin
         unique case (mode)
            MODE_32K: begin
               idx     = IDX_TOP;
               low_cnt = 2'd2;
            end
            MODE_16K: begin
               idx     = win[1] ? IDX_TOP : IDX_W'(2);
               low_cnt = 2'd1;
            end
            MODE_MIX: begin
               if (!win[1]) begin
                  idx     = IDX_W'(2);
                  low_cnt = 2'd1;
               end else begin
                  idx = win[0] ? IDX_TOP : IDX_W'(3);
               end
            end
            MODE_8K: idx = IDX_W'(win[1:0]) + IDX_W'(1);
            default: idx = IDX_TOP;
         endcase
      end
   end

endmodule

// File: rtl/prg_xlate_form.sv
module prg_xlate_form #(
   parameter int DW         = 8,
   parameter int RAM_BANK_W = 3,
   parameter int ROM_BANK_W = 7
) (
   input  logic [DW-1:0]         val,
   input  logic                  force_rom,
   input  logic                  force_ram,
   input  logic [1:0]            low_cnt,
   input  logic [1:0]            sub,       // cpu_addr[14:13]
   output logic                  is_rom,
   output logic [ROM_BANK_W-1:0] bank
);

   localparam int SEL_BIT = DW - 1;

   logic [ROM_BANK_W-1:0] base;
   logic [ROM_BANK_W-1:0] lmask;

   always_comb begin
      is_rom = force_rom | (~force_ram & val[SEL_BIT]);
      base   = is_rom ? val[ROM_BANK_W-1:0]
                      : ROM_BANK_W'(val[RAM_BANK_W-1:0]);
      unique case (low_cnt)
         2'd1:    lmask = ROM_BANK_W'(1);
         2'd2:    lmask = ROM_BANK_W'(3);
         default: lmask = '0;
      endcase
      bank = (base & ~lmask) | (ROM_BANK_W'(sub) & lmask);
   end

endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
   import prg_xlate_pkg::*;
#(
   parameter int DW         = 8,
   parameter int RA_W       = 8,
   parameter int CPU_AW     = 16,
   parameter int PAGE_W     = 13,
   parameter int RAM_BANK_W = 3,
   parameter int ROM_BANK_W = 7,
   localparam int PHYS_W    = ROM_BANK_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   input  logic [CPU_AW-1:0] cpu_addr,
   output logic [PHYS_W-1:0] phys_addr,
   output logic              sel_ram,
   output logic              ram_wr_ok
);

   localparam int IDX_W = $clog2(NUM_BANK);

   if (CPU_AW != PAGE_W + 3) begin : g_bad_aw
      $error("CPU_AW must equal PAGE_W + 3 (eight windows)");
   end
   if (ROM_BANK_W >= DW || RAM_BANK_W > ROM_BANK_W) begin : g_bad_bw
      $error("bank widths must fit below the select bit");
   end

   bank_mode_e                  mode_q;
   logic [1:0]                  key_a_q, key_b_q;
   logic [NUM_BANK-1:0][DW-1:0] bank_q;
   logic                        in_map;
   logic [IDX_W-1:0]            idx;
   logic [1:0]                  low_cnt;
   logic                        is_rom;
   logic [ROM_BANK_W-1:0]       bank;
   logic [2:0]                  win;

   assign win = cpu_addr[CPU_AW-1:PAGE_W];

   prg_xlate_regs #(.DW(DW), .RA_W(RA_W), .NB(NUM_BANK)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .mode_q  (mode_q),
      .key_a_q (key_a_q),
      .key_b_q (key_b_q),
      .bank_q  (bank_q)
   );

   prg_xlate_sel #(.NB(NUM_BANK), .IDX_W(IDX_W)) u_sel (
      .win     (win),
      .mode    (mode_q),
      .in_map  (in_map),
      .idx     (idx),
      .low_cnt (low_cnt)
   );

   prg_xlate_form #(.DW(DW), .RAM_BANK_W(RAM_BANK_W), .ROM_BANK_W(ROM_BANK_W)) u_form (
      .val       (bank_q[idx]),
      .force_rom (idx == IDX_W'(NUM_BANK-1)),
      .force_ram (idx == '0),
      .low_cnt   (low_cnt),
      .sub       (cpu_addr[PAGE_W+1:PAGE_W]),
      .is_rom    (is_rom),
      .bank      (bank)
   );

   assign sel_ram   = in_map & ~is_rom;
   assign phys_addr = in_map ? {bank, cpu_addr[PAGE_W-1:0]} : '0;
   assign ram_wr_ok = sel_ram & (key_a_q == KEY_A_VAL) & (key_b_q == KEY_B_VAL);

   // ---------------- assertions ----------------
   a_r2_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
      (win == 3'd3) |-> (sel_ram && phys_addr[PHYS_W-1:PAGE_W+RAM_BANK_W] == '0));

   a_r7_top_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (win == 3'd7) |-> !sel_ram);

   a_r3_mode0_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_32K && cpu_addr[CPU_AW-1]) |-> !sel_ram);

   a_r8_wr_needs_ram: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr_ok |-> sel_ram);

   a_r10_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (win >= 3'd3) |-> (phys_addr[PAGE_W-1:0] == cpu_addr[PAGE_W-1:0]));

   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (win < 3'd3) |-> (!sel_ram && !ram_wr_ok && phys_addr == '0));

   a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == RA_W'(OFF_MODE)) |=> $stable(mode_q));

endmodule

// File: tb/prg_bank_xlate_test.sv
module prg_bank_xlate_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [15:0] cpu_addr = '0;
   logic [19:0] phys_addr;
   logic        sel_ram;
   logic        ram_wr_ok;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // shadow configuration, built from the requirements
   logic [1:0] sh_mode;
   logic [1:0] sh_ka, sh_kb;
   logic [7:0] sh_bank [5];

   prg_bank_xlate uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
      .sel_ram(sel_ram), .ram_wr_ok(ram_wr_ok)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic shadow_reset();
      sh_mode = 2'd3; sh_ka = '0; sh_kb = '0;
      for (int i = 0; i < 5; i++) sh_bank[i] = (i == 4) ? 8'hFF : 8'h00;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a == 8'h00) sh_mode = d[1:0];
      if (a == 8'h02) sh_ka = d[1:0];
      if (a == 8'h03) sh_kb = d[1:0];
      if (a >= 8'h13 && a <= 8'h17) sh_bank[a - 8'h13] = d;
   endtask

   // returns {sel, wr, phys[19:0]}
   function automatic logic [21:0] ref_map(input logic [15:0] a);
      int         idx;
      int         lc;
      logic       rom;
      logic [7:0] r;
      logic [6:0] b, m;
      idx = 0; lc = 0;
      if (a < 16'h6000) return '0;
      if (a < 16'h8000) idx = 0;
      else begin
         case (sh_mode)
            2'd0: begin idx = 4; lc = 2; end
            2'd1: begin idx = (a >= 16'hC000) ? 4 : 2; lc = 1; end
            2'd2: begin
               if (a < 16'hC000) begin idx = 2; lc = 1; end
               else idx = (a >= 16'hE000) ? 4 : 3;
            end
            default: idx = 1 + int'(a[14:13]);
         endcase
      end
      r   = sh_bank[idx];
      rom = (idx == 4) || (idx != 0 && r[7]);
      b   = rom ? r[6:0] : {4'b0, r[2:0]};
      m   = (lc == 2) ? 7'd3 : (lc == 1) ? 7'd1 : 7'd0;
      b   = (b & ~m) | ({5'b0, a[14:13]} & m);
      return {!rom, !rom && sh_ka == 2'd2 && sh_kb == 2'd1, b, a[12:0]};
   endfunction

   function automatic string region_tag(input logic [15:0] a);
      if (a < 16'h6000) return "R10";
      if (a < 16'h8000) return "R2";
      case (sh_mode)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk_exp(input logic [15:0] a, input logic s, input logic w,
                          input logic [19:0] p, input string tag);
      @(negedge clk);
      cpu_addr = a;
      #1;
      checks++;
      if (sel_ram !== s || phys_addr !== p) begin
         errors++;
         $display("FAIL %s addr=%h sel/phys got %b/%h exp %b/%h", tag, a, sel_ram, phys_addr, s, p);
      end
      checks++;
      if (ram_wr_ok !== w) begin
         errors++;
         $display("FAIL R8 (%s) addr=%h wr_ok got %b exp %b", tag, a, ram_wr_ok, w);
      end
   endtask

   task automatic chk_ref(input logic [15:0] a);
      logic [21:0] e;
      e = ref_map(a);
      chk_exp(a, e[21], e[20], e[19:0], region_tag(a));
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] offs [12];
      void'($urandom(32'd1234));
      offs = '{8'h00, 8'h02, 8'h03, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17,
               8'h01, 8'h12, 8'h18, 8'h93};
      shadow_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset contents
      chk_exp(16'hE123, 1'b0, 1'b0, {7'h7F, 13'h0123}, "R9");
      chk_exp(16'h8004, 1'b1, 1'b0, 20'h00004, "R9");
      chk_exp(16'h6FFF, 1'b1, 1'b0, 20'h00FFF, "R9");
      chk_exp(16'h4000, 1'b0, 1'b0, 20'h0, "R10");

      // R2: bit 7 of B0 has no effect
      wr(8'h13, 8'h8E);
      chk_exp(16'h6001, 1'b1, 1'b0, {7'd6, 13'h0001}, "R2");

      // R8: write key
      wr(8'h02, 8'hFE); wr(8'h03, 8'h01);
      chk_exp(16'h6002, 1'b1, 1'b1, {7'd6, 13'h0002}, "R8");
      wr(8'h03, 8'h03);
      chk_exp(16'h6002, 1'b1, 1'b0, {7'd6, 13'h0002}, "R8");
      wr(8'h03, 8'h05);
      chk_exp(16'h6002, 1'b1, 1'b1, {7'd6, 13'h0002}, "R8");

      // R7: bit 7 of B1 selects ROM; B4 ROM even with bit 7 clear
      wr(8'h14, 8'h85);
      chk_exp(16'h8010, 1'b0, 1'b0, {7'd5, 13'h0010}, "R7");
      wr(8'h17, 8'h05);
      chk_exp(16'hE000, 1'b0, 1'b0, {7'd5, 13'h0000}, "R7");
      wr(8'h15, 8'h7A);
      chk_exp(16'hA000, 1'b1, 1'b1, {7'd2, 13'h0000}, "R7");

      // R3: mode 0 masking of the low two bits
      wr(8'h17, 8'h7F); wr(8'h00, 8'h00);
      chk_exp(16'hA000, 1'b0, 1'b0, {7'h7D, 13'h0000}, "R3");
      chk_exp(16'h8000, 1'b0, 1'b0, {7'h7C, 13'h0000}, "R3");

      // R1: unused offsets ignored
      wr(8'h93, 8'h01); wr(8'h01, 8'h03); wr(8'h18, 8'h00); wr(8'h12, 8'h55);
      chk_exp(16'h6003, 1'b1, 1'b1, {7'd6, 13'h0003}, "R1");
      chk_exp(16'hFFFF, 1'b0, 1'b0, {7'h7F, 13'h1FFF}, "R1");

      // random traffic against the reference function
      for (int it = 0; it < 400; it++) begin
         wr(offs[$urandom_range(0, 11)], 8'($urandom()));
         for (int k = 0; k < 4; k++) chk_ref(16'($urandom()));
      end

      // R4 / R5 / R6 sweeps over every window
      for (int md = 1; md < 4; md++) begin
         wr(8'h00, 8'(md));
         for (int w = 0; w < 8; w++) chk_ref({3'(w), 13'($urandom())});
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule